// File: doc/BRIEF.md
# Legacy Memory Window Router

This block steers every memory access that falls in the 768 KB to 1 MB window of a chip's address map, sending it either to the DRAM controller or to the memory-mapped I/O bus. The window is split into twelve 16 KB expansion segments from C0000 to EFFFF and one 64 KB system segment from F0000 to FFFFF. Each segment carries a 2-bit attribute that steers reads and writes separately. A segment can therefore be shadowed read-only, write-only or fully, or left entirely on the I/O side.

Seven byte-wide attribute registers are written and read back over a simple indexed register port. An access arrives as its 16 KB block number (address bits ADDR_W-1:14) with a write flag and a strobe. One clock later the block raises a valid flag together with exactly one of two routing outputs. Addresses outside the window always go to DRAM. Firmware must set every segment to read/write before the DRAM behind this window can be used or tested.

Top module: `legacy_route_top`

## Requirements
- R1: After reset every attribute is 00: all register reads return 0x00, no routing output is raised, and a legacy access is routed to I/O.
- R2: The attribute code steers an access as follows. 00 sends reads and writes to I/O. 01 sends reads to DRAM and writes to I/O. 10 sends writes to DRAM and reads to I/O. 11 sends both to DRAM. When route_valid is high, exactly one of route_dram and route_mmio is high.
- R3: Register index 0 holds the attribute of the 64 KB system segment F0000–FFFFF in bits 5:4. Its bits 1:0 read zero and ignore writes.
- R4: Register indices 1 to 6 each cover two adjacent 16 KB segments, in ascending order starting at C0000 for index 1. Bits 1:0 control the lower-addressed segment and bits 5:4 the higher one, so index 6 bits 5:4 control EC000–EFFFF.
- R5: An access whose address is below C0000 or at or above 1 MB (any of address bits ADDR_W-1:20 set) is routed to DRAM, whatever the attributes hold.
- R6: Bits 7:6 and 3:2 of every register read zero and ignore writes. Index 7 reads 0x00, and a write to it changes no register.
- R7: The routing result appears on the clock edge after the cycle in which acc_valid is high, with route_valid high. In the cycle after a cycle without a strobe, route_valid, route_dram and route_mmio are all low.
- R8: When a register write and an access to a segment of that register occur in the same cycle, the access is routed by the attribute that held before the write. The new attribute applies from the next access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index for write and read-back |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the register at cfg_idx (combinational) |
| acc_valid | input | 1 | Access strobe |
| acc_blk | input | ADDR_W-14 (18) | Access address bits ADDR_W-1:14 (16 KB block number) |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| route_valid | output | 1 | Routing result valid, one cycle after the strobe |
| route_dram | output | 1 | Access goes to DRAM |
| route_mmio | output | 1 | Access goes to the memory-mapped I/O bus |

## Verification
A register update and a lookup can fall in the same clock cycle and touch the same attribute. That is the one place where the storage and the decode interact. The bench provokes it on purpose in two ways. A directed step changes an I/O-only segment to read/write while a read of that segment is strobed, and the random phase issues writes and accesses together freely. The route is judged against a bench model that computes the expected result before it applies the write, so any forwarding of the new value into the access fails the check. The following access is then checked for the new value.

// File: rtl/legacy_route_pkg.sv
package legacy_route_pkg;

  // Attribute codes: bit 0 steers reads, bit 1 steers writes (1 = DRAM)
  typedef enum logic [1:0] {
    ATTR_MMIO_ONLY = 2'b00,
    ATTR_RD_DRAM   = 2'b01,
    ATTR_WR_DRAM   = 2'b10,
    ATTR_ALL_DRAM  = 2'b11
  } attr_e;

  // 16 KB block number of the first expansion segment (C0000 >> 14)
  localparam int unsigned WIN_BASE_BLK = 48;
  // Count of 16 KB expansion segments below the system segment
  localparam int unsigned EXP_SEGS     = 12;

  typedef struct packed {
    logic valid;
    logic dram;
    logic mmio;
  } route_t;

endpackage

// File: rtl/legacy_reset_sync.sv
module legacy_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/legacy_attr_regs.sv
module legacy_attr_regs
  import legacy_route_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_REGS-1:0][1:0] attr_lo,
  output logic [NUM_REGS-1:0][1:0] attr_hi
);

  localparam int unsigned LO_POS = 0;
  localparam int unsigned HI_POS = 4;

  logic [1:0] wr_lo;
  logic [1:0] wr_hi;
  logic       idx_ok;

  assign wr_lo  = wdata[LO_POS+1:LO_POS];
  assign wr_hi  = wdata[HI_POS+1:HI_POS];
  assign idx_ok = (idx < IDX_W'(NUM_REGS));

  // Reserved data bits are never stored
  logic unused_resv;
  assign unused_resv = ^{wdata[DATA_W-1:HI_POS+2], wdata[HI_POS-1:LO_POS+2]};

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic       sel;
    logic       hi_en;
    logic [1:0] hi_d;
    logic [1:0] hi_q;

    assign sel = wr_en && (idx == IDX_W'(r));

    always_comb begin
      hi_en = sel;
      hi_d  = wr_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_q <= ATTR_MMIO_ONLY;
      else if (hi_en) hi_q <= hi_d;
    end

    assign attr_hi[r] = hi_q;

    if (r == 0) begin : g_sys
      // System segment register has only the upper field
      assign attr_lo[r] = 2'b00;
    end else begin : g_exp
      logic       lo_en;
      logic [1:0] lo_d;
      logic [1:0] lo_q;

      always_comb begin
        lo_en = sel;
        lo_d  = wr_lo;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lo_q <= ATTR_MMIO_ONLY;
        else if (lo_en) lo_q <= lo_d;
      end

      assign attr_lo[r] = lo_q;
    end
  end

  always_comb begin
    rdata = '0;
    if (idx_ok) begin
      rdata[LO_POS+1:LO_POS] = attr_lo[idx];
      rdata[HI_POS+1:HI_POS] = attr_hi[idx];
    end
  end

endmodule

// File: rtl/legacy_region_lookup.sv
module legacy_region_lookup
  import legacy_route_pkg::*;
#(
  parameter int unsigned BLK_W    = 18,
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned IDX_W    = 3
) (
  input  logic [BLK_W-1:0]         blk,
  input  logic                     is_write,
  input  logic [NUM_REGS-1:0][1:0] attr_lo,
  input  logic [NUM_REGS-1:0][1:0] attr_hi,
  output logic                     to_dram
);

  logic       above_1m;
  logic [5:0] blk_lo6;

  assign blk_lo6 = blk[5:0];

  // Width variant: the check for addresses past 1 MB only exists when wider
  if (BLK_W > 6) begin : g_wide
    assign above_1m = |blk[BLK_W-1:6];
  end else begin : g_narrow
    assign above_1m = 1'b0;
  end

  logic             in_win;
  logic [3:0]       seg;
  logic             sys_seg;
  logic [IDX_W-1:0] ridx;
  logic [1:0]       attr;

  always_comb begin
    in_win  = !above_1m && (blk_lo6 >= 6'(WIN_BASE_BLK));
    seg     = 4'(blk_lo6 - 6'(WIN_BASE_BLK));
    sys_seg = (seg >= 4'(EXP_SEGS));
    ridx    = IDX_W'(seg[3:1]) + IDX_W'(1);
    if (sys_seg)     attr = attr_hi[0];
    else if (seg[0]) attr = attr_hi[ridx];
    else             attr = attr_lo[ridx];
    if (in_win) to_dram = is_write ? attr[1] : attr[0];
    else        to_dram = 1'b1;
  end

endmodule

// File: rtl/legacy_route_stage.sv
module legacy_route_stage
  import legacy_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic to_dram,
  output logic valid_o,
  output logic dram_o,
  output logic mmio_o
);

  route_t route_d;
  route_t route_q;

  always_comb begin
    route_d.valid = strobe;
    route_d.dram  = strobe && to_dram;
    route_d.mmio  = strobe && !to_dram;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_q <= '0;
    else        route_q <= route_d;
  end

  assign valid_o = route_q.valid;
  assign dram_o  = route_q.dram;
  assign mmio_o  = route_q.mmio;

endmodule

// File: rtl/legacy_route_top.sv
module legacy_route_top
  import legacy_route_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 7,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS + 1),
  localparam int unsigned BLK_W   = ADDR_W - 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic [BLK_W-1:0]  acc_blk,
  input  logic              acc_write,
  output logic              route_valid,
  output logic              route_dram,
  output logic              route_mmio
);

  logic                     rst_int_n;
  logic [NUM_REGS-1:0][1:0] attr_lo;
  logic [NUM_REGS-1:0][1:0] attr_hi;
  logic                     lookup_dram;

  legacy_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  legacy_attr_regs #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_we),
    .idx     (cfg_idx),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .attr_lo (attr_lo),
    .attr_hi (attr_hi)
  );

  legacy_region_lookup #(
    .BLK_W    (BLK_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_lookup (
    .blk      (acc_blk),
    .is_write (acc_write),
    .attr_lo  (attr_lo),
    .attr_hi  (attr_hi),
    .to_dram  (lookup_dram)
  );

  legacy_route_stage u_stage (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .strobe  (acc_valid),
    .to_dram (lookup_dram),
    .valid_o (route_valid),
    .dram_o  (route_dram),
    .mmio_o  (route_mmio)
  );

endmodule

// File: rtl/legacy_route_chk.sv
module legacy_route_chk #(
  parameter int unsigned BLK_W    = 18,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned NUM_REGS = 7
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              acc_valid,
  input logic [BLK_W-1:0]  acc_blk,
  input logic              route_valid,
  input logic              route_dram,
  input logic              route_mmio
);

  assert_strobe_valid_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_valid |=> route_valid);

  assert_idle_valid_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !acc_valid |=> !route_valid);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !route_valid |-> (!route_dram && !route_mmio));

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    route_valid |-> ($countones({route_dram, route_mmio}) == 1));

  assert_low_addr_dram_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && (acc_blk < BLK_W'(48))) |=> route_dram);

  assert_resv_zero_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_rdata[7:6] == 2'b00) && (cfg_rdata[3:2] == 2'b00));

  assert_bad_index_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_idx >= IDX_W'(NUM_REGS)) |-> (cfg_rdata == '0));

  assert_sys_low_field_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_idx == '0) |-> (cfg_rdata[1:0] == 2'b00));

endmodule

bind legacy_route_top legacy_route_chk #(
  .BLK_W    (BLK_W),
  .DATA_W   (DATA_W),
  .IDX_W    (IDX_W),
  .NUM_REGS (NUM_REGS)
) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .cfg_idx     (cfg_idx),
  .cfg_rdata   (cfg_rdata),
  .acc_valid   (acc_valid),
  .acc_blk     (acc_blk),
  .route_valid (route_valid),
  .route_dram  (route_dram),
  .route_mmio  (route_mmio)
);

// File: tb/legacy_route_top_test.sv
`timescale 1ns/1ps
module legacy_route_top_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        acc_valid;
  logic [17:0] acc_blk;
  logic        acc_write;
  logic        route_valid;
  logic        route_dram;
  logic        route_mmio;

  int unsigned n_checks;
  int unsigned n_errors;
  bit          finished;
  logic [7:0]  model [0:7];

  legacy_route_top uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .acc_valid   (acc_valid),
    .acc_blk     (acc_blk),
    .acc_write   (acc_write),
    .route_valid (route_valid),
    .route_dram  (route_dram),
    .route_mmio  (route_mmio)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_dram(input logic [31:0] addr, input logic wr);
    logic [5:0] b;
    int         seg;
    int         r;
    logic [1:0] a;
    b = addr[19:14];
    if (addr[31:20] != 0 || b < 6'd48) return 1'b1;
    seg = int'(b) - 48;
    if (seg >= 12) a = model[0][5:4];
    else begin
      r = 1 + seg / 2;
      a = (seg % 2 == 1) ? model[r][5:4] : model[r][1:0];
    end
    return wr ? a[1] : a[0];
  endfunction

  function automatic logic [7:0] keep_mask(input int idx);
    if (idx == 0) return 8'h30;
    if (idx < 7)  return 8'h33;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  // Called at a falling edge; returns at the next falling edge with outputs checked
  task automatic step(input logic we, input int idx, input logic [7:0] wd,
                      input logic av, input logic [31:0] addr, input logic wr,
                      input string req);
    logic e_dram;
    cfg_we    = we;
    cfg_idx   = 3'(idx);
    cfg_wdata = wd;
    acc_valid = av;
    acc_blk   = addr[31:14];
    acc_write = wr;
    e_dram    = exp_dram(addr, wr);
    @(posedge clk);
    if (we) model[idx] = wd & keep_mask(idx);
    @(negedge clk);
    check({req, " route_valid"}, {31'd0, route_valid}, {31'd0, av});
    check({req, " route_dram"},  {31'd0, route_dram},  {31'd0, av & e_dram});
    check({req, " route_mmio"},  {31'd0, route_mmio},  {31'd0, av & ~e_dram});
    check({req, " cfg_rdata"},   {24'd0, cfg_rdata},   {24'd0, model[idx]});
    cfg_we    = 1'b0;
    acc_valid = 1'b0;
  endtask

  task automatic rd_check(input int idx, input string req);
    cfg_idx = 3'(idx);
    #1;
    check(req, {24'd0, cfg_rdata}, {24'd0, model[idx]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    n_checks = 0;
    n_errors = 0;
    finished = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_blk = '0; acc_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 8; i++) rd_check(i, "R1 reset read");
    check("R1 reset no route", {29'd0, route_valid, route_dram, route_mmio}, 32'd0);
    step(0, 0, 0, 1, 32'h000F_0000, 0, "R1 reset legacy read");
    step(0, 0, 0, 1, 32'h000C_4000, 1, "R1 reset legacy write");

    // R3/R6: system register, reserved bits
    step(1, 0, 8'hFF, 0, 0, 0, "R6 reserved bits on index 0");
    step(0, 0, 0, 1, 32'h000F_0000, 0, "R3 system read all-dram");
    step(0, 0, 0, 1, 32'h000F_C000, 1, "R3 system write all-dram");
    // R2: read-only and write-only codes
    step(1, 0, 8'h10, 0, 0, 0, "R2 program 01");
    step(0, 0, 0, 1, 32'h000F_8000, 0, "R2 code 01 read");
    step(0, 0, 0, 1, 32'h000F_8000, 1, "R2 code 01 write");
    step(1, 0, 8'h20, 0, 0, 0, "R2 program 10");
    step(0, 0, 0, 1, 32'h000F_4000, 0, "R2 code 10 read");
    step(0, 0, 0, 1, 32'h000F_4000, 1, "R2 code 10 write");

    // R4: segment ordering and field positions
    step(1, 1, 8'h21, 0, 0, 0, "R4 program index 1");
    step(0, 1, 0, 1, 32'h000C_0000, 0, "R4 C0000 read");
    step(0, 1, 0, 1, 32'h000C_0000, 1, "R4 C0000 write");
    step(0, 1, 0, 1, 32'h000C_4000, 0, "R4 C4000 read");
    step(0, 1, 0, 1, 32'h000C_7FFF, 1, "R4 C4000 write");
    step(1, 6, 8'h1F, 0, 0, 0, "R6 reserved bits on index 6");
    step(0, 6, 0, 1, 32'h000E_8000, 1, "R4 E8000 write");
    step(0, 6, 0, 1, 32'h000E_C000, 0, "R4 EC000 read");
    step(0, 6, 0, 1, 32'h000E_FFFF, 1, "R4 EC000 write");
    step(0, 4, 0, 1, 32'h000D_8000, 0, "R4 D8000 untouched");

    // R6: index 7 ignored
    step(1, 7, 8'hFF, 0, 0, 0, "R6 index 7 write");
    for (int i = 0; i < 8; i++) rd_check(i, "R6 registers after index 7 write");

    // R5: outside the window
    step(0, 0, 0, 1, 32'h0008_0000, 1, "R5 below window");
    step(0, 0, 0, 1, 32'h000B_C000, 0, "R5 just below C0000");
    step(0, 0, 0, 1, 32'h001F_4000, 0, "R5 above 1 MB alias");
    step(0, 0, 0, 1, 32'hFFFF_C000, 1, "R5 top of space");

    // R8: write and access in the same cycle
    step(1, 2, 8'h33, 1, 32'h000C_8000, 0, "R8 same-cycle old attribute");
    step(0, 2, 0, 1, 32'h000C_8000, 0, "R8 new attribute next access");
    step(1, 2, 8'h00, 1, 32'h000C_C000, 1, "R8 same-cycle clear");
    step(0, 2, 0, 1, 32'h000C_C000, 1, "R8 cleared next access");

    // R7: idle cycle
    step(0, 3, 0, 0, 32'h000D_0000, 0, "R7 idle cycle");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      int          sel;
      sel = int'($urandom % 8);
      if (sel < 6)       a = 32'h000C_0000 + (($urandom % 32'h40000) & 32'hFFFF_C000);
      else if (sel == 6) a = ($urandom % 32'hC0000) & 32'hFFFF_C000;
      else               a = $urandom & 32'hFFFF_C000;
      step(1'($urandom % 3 == 0), int'($urandom % 8), 8'($urandom),
           1'($urandom % 4 != 0), a, 1'($urandom), "R2 R4 R8 random");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule